// File: doc/BRIEF.md
# Twin Countdown Timer Pair with Shared Interrupt

This block places two identical countdown timers behind a single 4 KB register window and drives one interrupt line that is raised whenever either timer requests service. A host reaches both timers through the same read and write strobes. The block splits the window by address, so that the low slice addresses the first timer and the next slice addresses the second timer. The second slice is translated down to the same local offsets before the access reaches that timer.

Both timers share one tick input. On each tick, a running timer counts down. When a timer reaches zero, it raises its own flag, reloads, and stops if it is set to single-shot. Read data is registered: it appears one cycle after the read strobe and comes only from the addressed timer. Any access that falls past the two timer slices reads as zero and changes nothing.

The address port carries word addresses, so byte offset = 4 × `addr`.

Top module: `dual_timer_wrap`

## Requirements
- R1: Byte offsets 0x00–0x1F reach timer A. Byte offsets 0x20–0x3F reach timer B, with 0x20 removed, so that the same local register layout applies to both timers.
- R2: Read data appears on `rdata` in the cycle after a cycle with `rd_en` high. In any cycle not preceded by a read strobe, `rdata` is zero.
- R3: A write reaches only the addressed timer. The registers of the other timer keep their values.
- R4: `irq` is high whenever either timer's interrupt request is high.
- R5: Reads at byte offsets 0x40 and above inside the 0x1000-byte window return zero. Writes there change no register.
- R6: The local registers of each timer are as follows:
  - 0x00: reload value. Writing it also loads the counter.
  - 0x04: counter. Read-only; writes are ignored.
  - 0x08: control. Bit 0 = run, bit 1 = interrupt enable, bit 2 = single-shot.
  - 0x0C: writing any value clears the flag.
  - 0x10: raw flag in bit 0.
  - Other local offsets read zero.
- R7: While run is set, each tick decrements the counter. A tick seen at zero sets the flag and reloads the counter. In single-shot mode, that tick also clears run.
- R8: A timer requests an interrupt only while its flag and its interrupt enable are both set.
- R9: After reset, all registers are zero, `rdata` is zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Shared count-enable pulse for both timers |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 10 | Word address inside the window (byte offset / 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt of both timers |

## Verification
The bench builds the block with its default parameters: a 32-byte slice per timer, two timers, a 10-bit word address and 32-bit data. With these values, both slice boundaries (0x1F/0x20 and 0x3F/0x40) and the top of the window are reached by plain accesses. Small reload values bring expiry, reload and single-shot stop within a few ticks. Setting up timer B while timer A holds state shows whether steering and translation keep the two timers apart.

// File: rtl/dtw_pkg.sv
package dtw_pkg;

    localparam int unsigned DATA_W      = 32;
    localparam int unsigned WIN_BYTES   = 4096;
    localparam int unsigned SLICE_BYTES = 32;
    localparam int unsigned N_TMR       = 2;

    // Local word index of each timer register
    typedef enum logic [2:0] {
        REG_RELOAD = 3'd0,
        REG_COUNT  = 3'd1,
        REG_CTRL   = 3'd2,
        REG_CLEAR  = 3'd3,
        REG_FLAG   = 3'd4
    } reg_idx_e;

    // Control word: run is bit 0, irq enable bit 1, single-shot bit 2
    typedef struct packed {
        logic oneshot;
        logic irq_en;
        logic run;
    } ctrl_t;

    function automatic int unsigned words_of(input int unsigned bytes);
        return bytes / 4;
    endfunction

endpackage

// File: rtl/dtw_decode.sv
module dtw_decode
    import dtw_pkg::*;
#(
    parameter int unsigned WADDR_W = 10,
    parameter int unsigned SLICE_W = 8,
    parameter int unsigned NT      = 2,
    localparam int unsigned LOC_W  = $clog2(SLICE_W),
    localparam int unsigned IDX_W  = WADDR_W - LOC_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WADDR_W-1:0] waddr,
    input  logic               wr_en,
    output logic [NT-1:0]      sel,
    output logic [NT-1:0]      wr_vec,
    output logic               hit,
    output logic [LOC_W-1:0]   loc
);

    logic [IDX_W-1:0] idx;

    assign idx = waddr[WADDR_W-1:LOC_W];
    // Dropping the upper bits removes the slice base of the selected timer
    assign loc = waddr[LOC_W-1:0];
    assign hit = |sel;

    for (genvar i = 0; i < NT; i++) begin : g_sel
        assign sel[i]    = (idx == IDX_W'(i));
        assign wr_vec[i] = wr_en & sel[i];
    end

    // R3: at most one timer sees a write enable
    a_r3_single_write: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_vec));

endmodule

// File: rtl/dtw_timer.sv
module dtw_timer
    import dtw_pkg::*;
#(
    parameter int unsigned DW    = 32,
    parameter int unsigned LOC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             we,
    input  logic [LOC_W-1:0] ridx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rd_val,
    output logic             irq
);

    logic [DW-1:0] reload_q;
    logic [DW-1:0] cnt_q;
    ctrl_t         ctrl_q;
    logic          flag_q;
    logic          expire;

    assign expire = ctrl_q.run && tick && (cnt_q == '0);
    assign irq    = flag_q && ctrl_q.irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            cnt_q    <= '0;
            ctrl_q   <= '0;
            flag_q   <= 1'b0;
        end else begin
            if (ctrl_q.run && tick) begin
                if (cnt_q == '0) begin
                    flag_q <= 1'b1;
                    cnt_q  <= reload_q;
                    if (ctrl_q.oneshot) ctrl_q.run <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
            if (we) begin
                case (ridx)
                    LOC_W'(REG_RELOAD): begin
                        reload_q <= wdata;
                        cnt_q    <= wdata;
                    end
                    LOC_W'(REG_CTRL):  ctrl_q <= ctrl_t'(wdata[2:0]);
                    LOC_W'(REG_CLEAR): if (!expire) flag_q <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_val = '0;
        case (ridx)
            LOC_W'(REG_RELOAD): rd_val = reload_q;
            LOC_W'(REG_COUNT):  rd_val = cnt_q;
            LOC_W'(REG_CTRL):   rd_val = {{(DW-3){1'b0}}, ctrl_q};
            LOC_W'(REG_FLAG):   rd_val = {{(DW-1){1'b0}}, flag_q};
            default:            rd_val = '0;
        endcase
    end

    // R7: expiry without a competing write reloads and flags
    a_r7_expire_reload: assert property (@(posedge clk) disable iff (rst)
        (expire && !we) |=> (flag_q && cnt_q == $past(reload_q)));

    // R6: a stopped timer with no write keeps its count
    a_r6_count_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run && !we) |=> $stable(cnt_q));

endmodule

// File: rtl/dual_timer_wrap.sv
module dual_timer_wrap
    import dtw_pkg::*;
#(
    parameter int unsigned DW       = DATA_W,
    parameter int unsigned WIN_B    = WIN_BYTES,
    parameter int unsigned SLICE_B  = SLICE_BYTES,
    parameter int unsigned NT       = N_TMR,
    localparam int unsigned WADDR_W = $clog2(words_of(WIN_B)),
    localparam int unsigned SLICE_W = words_of(SLICE_B),
    localparam int unsigned LOC_W   = $clog2(SLICE_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [WADDR_W-1:0] addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    output logic               irq
);

    logic [NT-1:0]    sel;
    logic [NT-1:0]    wr_vec;
    logic [NT-1:0]    irq_vec;
    logic             hit;
    logic [LOC_W-1:0] loc;
    logic [DW-1:0]    rv [NT];
    logic [DW-1:0]    rmux;
    logic [DW-1:0]    rdata_q;

    dtw_decode #(.WADDR_W(WADDR_W), .SLICE_W(SLICE_W), .NT(NT)) u_decode (
        .clk(clk), .rst(rst), .waddr(addr), .wr_en(wr_en),
        .sel(sel), .wr_vec(wr_vec), .hit(hit), .loc(loc)
    );

    for (genvar i = 0; i < NT; i++) begin : g_tmr
        dtw_timer #(.DW(DW), .LOC_W(LOC_W)) u_tmr (
            .clk(clk), .rst(rst), .tick(tick), .we(wr_vec[i]),
            .ridx(loc), .wdata(wdata), .rd_val(rv[i]), .irq(irq_vec[i])
        );
    end

    always_comb begin
        rmux = '0;
        for (int i = 0; i < NT; i++) begin
            if (sel[i]) rmux = rmux | rv[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else     rdata_q <= rd_en ? rmux : '0;
    end

    assign rdata = rdata_q;
    assign irq   = |irq_vec;

    // R2: no read strobe last cycle means zero read data
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en) |-> (rdata == '0));

    // R5: a read past the timer slices returns zero
    a_r5_oob_read_zero: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en && !hit) |-> (rdata == '0));

    // R5: a write past the timer slices enables no timer
    a_r5_oob_no_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr >= WADDR_W'(NT * SLICE_W)) |-> (wr_vec == '0));

endmodule

// File: tb/dual_timer_wrap_bench.sv
`timescale 1ns/100ps
module dual_timer_wrap_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dual_timer_wrap u_dual_timer_wrap (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    typedef struct packed {
        logic        is_wr;
        logic [11:0] boff;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 12'h000, 32'h0000_1234, 4'd1},  // R1 write A reload
        '{1'b1, 12'h020, 32'h0000_ABCD, 4'd1},  // R1 write B reload
        '{1'b0, 12'h000, 32'h0000_1234, 4'd1},  // R1
        '{1'b0, 12'h020, 32'h0000_ABCD, 4'd3},  // R3 B kept apart from A
        '{1'b0, 12'h004, 32'h0000_1234, 4'd6},  // R6 reload loads count
        '{1'b0, 12'h024, 32'h0000_ABCD, 4'd6},
        '{1'b1, 12'h004, 32'h0000_5555, 4'd6},  // R6 count is read-only
        '{1'b0, 12'h004, 32'h0000_1234, 4'd6},
        '{1'b1, 12'h040, 32'h0000_7777, 4'd5},  // R5 write past slices
        '{1'b0, 12'h040, 32'h0000_0000, 4'd5},
        '{1'b0, 12'hFFC, 32'h0000_0000, 4'd5},
        '{1'b0, 12'h000, 32'h0000_1234, 4'd5},  // R5 A untouched
        '{1'b1, 12'h028, 32'h0000_0003, 4'd3},  // R3 B control
        '{1'b0, 12'h028, 32'h0000_0003, 4'd3},
        '{1'b0, 12'h008, 32'h0000_0000, 4'd3},  // R3 A control untouched
        '{1'b0, 12'h014, 32'h0000_0000, 4'd6},  // R6 unused offset reads 0
        '{1'b1, 12'h028, 32'h0000_0000, 4'd3}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] boff, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = boff[11:2]; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] boff, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = boff[11:2];
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 rdata", rdata, 32'h0);
        check("R9 irq", {31'h0, irq}, 32'h0);
        do_read(12'h008, v); check("R9 ctrl A", v, 32'h0);
        do_read(12'h024, v); check("R9 count B", v, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_wr) begin
                do_write(VEC[i].boff, VEC[i].data);
            end else begin
                do_read(VEC[i].boff, v);
                check($sformatf("R%0d vec%0d", VEC[i].req, i), v, VEC[i].data);
            end
        end

        // R2: latency and idle zero
        do_read(12'h000, v); check("R2 data", v, 32'h1234);
        @(negedge clk); check("R2 idle", rdata, 32'h0);

        // R7 / R4: timer A counts 2,1,0 then expires
        do_write(12'h000, 32'd2);
        do_write(12'h008, 32'd3);
        do_tick(); do_tick();
        check("R7 no irq yet", {31'h0, irq}, 32'h0);
        do_read(12'h004, v); check("R7 count at zero", v, 32'h0);
        do_tick();
        check("R4 irq from A", {31'h0, irq}, 32'h1);
        do_read(12'h010, v); check("R7 A flag", v, 32'h1);
        do_read(12'h030, v); check("R3 B flag clear", v, 32'h0);
        do_read(12'h004, v); check("R7 reloaded", v, 32'h2);
        do_write(12'h00C, 32'h0);
        check("R6 clear drops irq", {31'h0, irq}, 32'h0);
        do_write(12'h008, 32'h0);

        // R8 / R7: timer B single-shot, irq masked then enabled
        do_write(12'h020, 32'h0);
        do_write(12'h028, 32'h5);
        do_tick();
        check("R8 masked", {31'h0, irq}, 32'h0);
        do_read(12'h030, v); check("R7 B flag", v, 32'h1);
        do_read(12'h028, v); check("R7 single-shot stop", v, 32'h4);
        do_write(12'h028, 32'h2);
        check("R8 enabled", {31'h0, irq}, 32'h1);
        do_write(12'h00C, 32'h0);
        check("R3 clear A leaves B", {31'h0, irq}, 32'h1);
        do_write(12'h02C, 32'h0);
        check("R1 clear B via offset", {31'h0, irq}, 32'h0);

        finish_run();
    end

endmodule